// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the feedback divider of a frequency synthesizer loop. It divides a fast input clock by a programmable ratio N = B·P + A and emits one pulse per N input cycles toward a phase detector. The ratio is not produced by one plain counter. A dual-modulus prescaler divides by P or P+1. A swallow counter (A) keeps the prescaler in its P+1 mode for the first A prescaler cycles of each output period. A main counter (B) counts B prescaler cycles per output period. The prescaler is a synchronous divide-by-4/5 core extended by a small binary counter. One select bit picks a base modulus of 32 or 64.

New A, B and modulus values are captured on a load strobe into a staging register. They reach the counters only when the main counter wraps, so an output period that is already in progress always runs to its end. A configuration flag reports a captured ratio that the pulse-swallow scheme cannot produce faithfully. Every width, the core modulus and both base moduli are parameters. Generate blocks choose between a binary and a one-hot 4/5 core, and between a registered and a combinational output pulse.

Top module: `psw_fb_divider`

## Requirements
- R1: With `msel_i` = 0 (base modulus P = 32) and a legal ratio (B ≥ 2, B ≥ A), consecutive `pulse_o` pulses are exactly B·32 + A input cycles apart.
- R2: With `msel_i` = 1 (base modulus P = 64) and a legal ratio, consecutive `pulse_o` pulses are exactly B·64 + A input cycles apart.
- R3: The A value covers its full 6-bit range: A = 0 gives a period of exactly B·P, and A = 63 gives exactly B·P + 63, including the edge case B = A = 63.
- R4: `pulse_o` is high for exactly one input clock cycle per output period.
- R5: Values presented with `ld_i` high take effect only at the next wrap of the main counter. The period in progress when `ld_i` is pulsed keeps the previous ratio, and the period after it uses the new ratio.
- R6: One cycle after a clock edge with `ld_i` high, `cfg_err_o` is 1 if the captured `b_i` is below 2 or below the captured `a_i`, and 0 otherwise. It holds that value until the next load.
- R7: When a captured ratio has B ≥ 2 and B < A, every prescaler cycle of the period is stretched, giving a period of B·(P+1).
- R8: After `rst_ni` is released, `pulse_o` and `cfg_err_o` are 0 and the divider runs with the reset ratio A = 0, B = 2, P = 32, a period of 64 cycles.
- R9: Changes on `a_i`, `b_i` or `msel_i` while `ld_i` is low do not change the output period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ld_i | input | 1 | Strobe that captures `a_i`, `b_i`, `msel_i` into staging |
| a_i | input | A_W (6) | Swallow count A, 0 to 63 |
| b_i | input | B_W (11) | Main count B, 2 to 2047 |
| msel_i | input | 1 | Base modulus: 0 selects 32/33, 1 selects 64/65 |
| pulse_o | output | 1 | One-cycle pulse per N input cycles |
| cfg_err_o | output | 1 | Captured ratio is illegal (B < 2 or B < A) |

## Verification
A wrong internal state shows up in the spacing of `pulse_o`. A mis-timed 4/5 core or swallow decision moves the next pulse by one or more cycles. That error becomes visible at the first pulse after the fault, at most one output period later. A staging fault that applies values early shortens the period in progress, and one that applies them late lengthens the period after it. Both show in the two periods that follow a load. The bench therefore measures every period around each load for both moduli, across a spread of swallow counts that includes 0 and 63, and for ratios with B below A.

// File: rtl/psw_pkg.sv
package psw_pkg;

   // Base modulus choice for the dual-modulus prescaler
   typedef enum logic {
      PS_LO = 1'b0,
      PS_HI = 1'b1
   } ps_sel_e;

   // A ratio is unusable when the main count is below two or when
   // the swallow count exceeds the main count.
   function automatic logic ratio_illegal(input logic [31:0] a_val,
                                          input logic [31:0] b_val);
      return (b_val < 32'd2) || (b_val < a_val);
   endfunction

endpackage

// File: rtl/psw_cfg_stage.sv
module psw_cfg_stage
   import psw_pkg::*;
#(
   parameter int      A_W     = 6,
   parameter int      B_W     = 11,
   parameter int      RST_A   = 0,
   parameter int      RST_B   = 2,
   parameter ps_sel_e RST_SEL = PS_LO
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           ld_i,
   input  logic [A_W-1:0] a_i,
   input  logic [B_W-1:0] b_i,
   input  ps_sel_e        sel_i,
   input  logic           commit_i,
   output logic [A_W-1:0] nxt_a_o,
   output logic [B_W-1:0] nxt_b_o,
   output ps_sel_e        act_sel_o,
   output logic           err_o
);

   logic [A_W-1:0] stg_a_q;
   logic [B_W-1:0] stg_b_q;
   ps_sel_e        stg_sel_q;
   ps_sel_e        act_sel_q;
   logic           err_q;

   // Staging registers: written only by the load strobe
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stg_a_q   <= A_W'(RST_A);
         stg_b_q   <= B_W'(RST_B);
         stg_sel_q <= RST_SEL;
         err_q     <= 1'b0;
      end else if (ld_i) begin
         stg_a_q   <= a_i;
         stg_b_q   <= b_i;
         stg_sel_q <= sel_i;
         err_q     <= ratio_illegal(32'(a_i), 32'(b_i));
      end
   end

   // Active modulus: moves only when the counter chain wraps
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         act_sel_q <= RST_SEL;
      end else if (commit_i) begin
         act_sel_q <= stg_sel_q;
      end
   end

   assign nxt_a_o   = stg_a_q;
   assign nxt_b_o   = stg_b_q;
   assign act_sel_o = act_sel_q;
   assign err_o     = err_q;

   AST_SEL_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !commit_i |=> $stable(act_sel_q)); // R5

   AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ld_i |=> $stable(err_q)); // R6

   AST_STAGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ld_i |=> ($stable(stg_a_q) && $stable(stg_b_q))); // R9

endmodule

// File: rtl/psw_prescaler.sv
module psw_prescaler
   import psw_pkg::*;
#(
   parameter int CORE_MOD    = 4,
   parameter int P_LO        = 32,
   parameter int P_HI        = 64,
   parameter bit CORE_ONEHOT = 1'b0
) (
   input  logic    clk_i,
   input  logic    rst_ni,
   input  ps_sel_e sel_i,
   input  logic    swallow_i,
   output logic    tc_o
);

   localparam int EXT_LO  = P_LO / CORE_MOD;
   localparam int EXT_HI  = P_HI / CORE_MOD;
   localparam int EXT_MAX = (EXT_HI > EXT_LO) ? EXT_HI : EXT_LO;
   localparam int EXT_W   = (EXT_MAX > 1) ? $clog2(EXT_MAX) : 1;
   localparam int CORE_W  = $clog2(CORE_MOD + 1);
   localparam int SPAN_W  = $clog2(EXT_MAX * CORE_MOD + 2);

   logic [EXT_W-1:0] ext_q;
   logic [EXT_W-1:0] ext_last;
   logic             ext_at_last;
   logic             stretch;
   logic             core_end;

   // Extension counter terminal depends on the active base modulus
   assign ext_last    = (sel_i == PS_HI) ? EXT_W'(EXT_HI - 1) : EXT_W'(EXT_LO - 1);
   assign ext_at_last = (ext_q == ext_last);
   // The extra input cycle is taken once, in the last core pass
   assign stretch     = swallow_i && ext_at_last;

   if (CORE_ONEHOT) begin : g_core_onehot
      logic [CORE_MOD:0] oh_q;

      assign core_end = stretch ? oh_q[CORE_MOD] : oh_q[CORE_MOD-1];

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            oh_q <= (CORE_MOD+1)'(1);
         end else if (core_end) begin
            oh_q <= (CORE_MOD+1)'(1);
         end else begin
            oh_q <= {oh_q[CORE_MOD-1:0], 1'b0};
         end
      end

      AST_CORE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $countones(oh_q) == 1); // R1
   end else begin : g_core_binary
      logic [CORE_W-1:0] core_q;

      assign core_end = stretch ? (core_q == CORE_W'(CORE_MOD))
                                : (core_q == CORE_W'(CORE_MOD - 1));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            core_q <= '0;
         end else if (core_end) begin
            core_q <= '0;
         end else begin
            core_q <= core_q + CORE_W'(1);
         end
      end

      AST_CORE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
         core_q <= CORE_W'(CORE_MOD)); // R1
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ext_q <= '0;
      end else if (core_end) begin
         ext_q <= ext_at_last ? '0 : ext_q + EXT_W'(1);
      end
   end

   assign tc_o = core_end && ext_at_last;

   // Length of each prescaler cycle, measured independently of the core
   logic [SPAN_W-1:0] span_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         span_q <= '0;
      end else if (tc_o) begin
         span_q <= '0;
      end else begin
         span_q <= span_q + SPAN_W'(1);
      end
   end

   AST_PRESCALE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tc_o |-> (32'(span_q) + 32'd1 ==
                32'((sel_i == PS_HI) ? P_HI : P_LO) + 32'(swallow_i))); // R1

   AST_TC_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tc_o |=> !tc_o); // R4

endmodule

// File: rtl/psw_swallow_chain.sv
module psw_swallow_chain #(
   parameter int A_W   = 6,
   parameter int B_W   = 11,
   parameter int RST_A = 0,
   parameter int RST_B = 2
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           tc_i,
   input  logic [A_W-1:0] ld_a_i,
   input  logic [B_W-1:0] ld_b_i,
   output logic           swallow_o,
   output logic           wrap_o
);

   logic [A_W-1:0] a_cnt_q;
   logic [B_W-1:0] b_cnt_q;
   logic           b_last;

   // A main count of zero or one both end the period on this prescaler cycle
   assign b_last    = (b_cnt_q <= B_W'(1));
   assign wrap_o    = tc_i && b_last;
   assign swallow_o = (a_cnt_q != '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         a_cnt_q <= A_W'(RST_A);
         b_cnt_q <= B_W'(RST_B);
      end else if (tc_i) begin
         if (b_last) begin
            a_cnt_q <= ld_a_i;
            b_cnt_q <= ld_b_i;
         end else begin
            b_cnt_q <= b_cnt_q - B_W'(1);
            if (a_cnt_q != '0) begin
               a_cnt_q <= a_cnt_q - A_W'(1);
            end
         end
      end
   end

   AST_SWALLOW_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tc_i && !b_last && (a_cnt_q == '0)) |=> (a_cnt_q == '0)); // R1

   AST_COUNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tc_i |=> ($stable(a_cnt_q) && $stable(b_cnt_q))); // R2

endmodule

// File: rtl/psw_fb_divider.sv
module psw_fb_divider
   import psw_pkg::*;
#(
   parameter int A_W         = 6,
   parameter int B_W         = 11,
   parameter int CORE_MOD    = 4,
   parameter int P_LO        = 32,
   parameter int P_HI        = 64,
   parameter bit CORE_ONEHOT = 1'b0,
   parameter bit OUT_REG     = 1'b1,
   parameter int RST_A       = 0,
   parameter int RST_B       = 2,
   parameter bit RST_SEL     = 1'b0
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           ld_i,
   input  logic [A_W-1:0] a_i,
   input  logic [B_W-1:0] b_i,
   input  logic           msel_i,
   output logic           pulse_o,
   output logic           cfg_err_o
);

   localparam ps_sel_e RST_SEL_E = ps_sel_e'(RST_SEL);

   // Elaboration-time parameter checks
   if (CORE_MOD < 2) begin : g_chk_core
      $error("CORE_MOD must be at least 2");
   end
   if ((P_LO % CORE_MOD) != 0 || (P_HI % CORE_MOD) != 0) begin : g_chk_mult
      $error("base moduli must be multiples of CORE_MOD");
   end
   if (P_LO / CORE_MOD < 2 || P_HI <= P_LO) begin : g_chk_order
      $error("need P_LO >= 2*CORE_MOD and P_HI > P_LO");
   end
   if (RST_B < 2 || RST_A > RST_B || RST_B >= (1 << B_W) || RST_A >= (1 << A_W)) begin : g_chk_rst
      $error("reset ratio must be legal and fit its counters");
   end

   logic [A_W-1:0] nxt_a;
   logic [B_W-1:0] nxt_b;
   ps_sel_e        act_sel;
   logic           swallow;
   logic           tc;
   logic           wrap;

   psw_cfg_stage #(
      .A_W    (A_W),
      .B_W    (B_W),
      .RST_A  (RST_A),
      .RST_B  (RST_B),
      .RST_SEL(RST_SEL_E)
   ) u_cfg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ld_i     (ld_i),
      .a_i      (a_i),
      .b_i      (b_i),
      .sel_i    (ps_sel_e'(msel_i)),
      .commit_i (wrap),
      .nxt_a_o  (nxt_a),
      .nxt_b_o  (nxt_b),
      .act_sel_o(act_sel),
      .err_o    (cfg_err_o)
   );

   psw_prescaler #(
      .CORE_MOD   (CORE_MOD),
      .P_LO       (P_LO),
      .P_HI       (P_HI),
      .CORE_ONEHOT(CORE_ONEHOT)
   ) u_pre (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sel_i    (act_sel),
      .swallow_i(swallow),
      .tc_o     (tc)
   );

   psw_swallow_chain #(
      .A_W  (A_W),
      .B_W  (B_W),
      .RST_A(RST_A),
      .RST_B(RST_B)
   ) u_chain (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tc_i     (tc),
      .ld_a_i   (nxt_a),
      .ld_b_i   (nxt_b),
      .swallow_o(swallow),
      .wrap_o   (wrap)
   );

   if (OUT_REG) begin : g_out_reg
      logic pulse_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            pulse_q <= 1'b0;
         end else begin
            pulse_q <= wrap;
         end
      end
      assign pulse_o = pulse_q;
   end else begin : g_out_comb
      assign pulse_o = wrap;
   end

   AST_PULSE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_o |=> !pulse_o); // R4

   AST_WRAP_ON_TC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap |-> tc); // R5

endmodule

// File: tb/psw_fb_divider_tb.sv
module psw_fb_divider_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld = 1'b0;
   logic [5:0]  a_in = '0;
   logic [10:0] b_in = '0;
   logic        msel = 1'b0;
   logic        pulse;
   logic        cfg_err;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int npulse = 0;
   int last_t = 0;
   int prev_t = 0;
   int width_bad = 0;
   logic pulse_prev = 1'b0;
   int cur_n = 64;

   always #10 clk = ~clk;   // 50 MHz

   psw_fb_divider u_dut (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .ld_i     (ld),
      .a_i      (a_in),
      .b_i      (b_in),
      .msel_i   (msel),
      .pulse_o  (pulse),
      .cfg_err_o(cfg_err)
   );

   // Sample outputs away from the active edge
   always @(negedge clk) begin
      cyc = cyc + 1;
      if (pulse) begin
         if (pulse_prev) width_bad = width_bad + 1;
         prev_t = last_t;
         last_t = cyc;
         npulse = npulse + 1;
      end
      pulse_prev = pulse;
   end

   function automatic int exp_period(input int av, input int bv, input int sv);
      int p;
      p = (sv != 0) ? 64 : 32;
      if (bv < av) return bv * (p + 1);
      return bv * p + av;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks = checks + 1;
      if (act != exp) begin
         fails = fails + 1;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic next_period(output int per);
      int t0;
      t0 = npulse;
      wait (npulse > t0);
      per = last_t - prev_t;
   endtask

   // Load a ratio a few cycles after a pulse, then check the error flag,
   // the period in progress (old ratio) and the following one (new ratio)
   task automatic apply_cfg(input int av, input int bv, input int sv, input string req);
      int per;
      int t0;
      int exp_new;
      t0 = npulse;
      wait (npulse > t0);
      repeat (2) @(posedge clk);
      #2;
      a_in = 6'(av);
      b_in = 11'(bv);
      msel = sv[0];
      ld   = 1'b1;
      @(posedge clk);
      #2;
      ld = 1'b0;
      @(negedge clk);
      check("R6 cfg_err_o", int'(cfg_err), ((bv < 2) || (bv < av)) ? 1 : 0);
      next_period(per);
      check("R5 period in progress keeps old ratio", per, cur_n);
      exp_new = exp_period(av, bv, sv);
      next_period(per);
      check(req, per, exp_new);
      cur_n = exp_new;
   endtask

   initial begin
      int per;
      repeat (5) @(posedge clk);
      #2;
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 pulse_o after reset", int'(pulse), 0);
      check("R8 cfg_err_o after reset", int'(cfg_err), 0);
      next_period(per);
      next_period(per);
      check("R8 reset ratio period", per, 64);

      // P = 32 sweep of the swallow count, B just above A
      for (int av = 0; av <= 63; av = av + 7) begin
         apply_cfg(av, av + 2, 0, (av == 0 || av == 63) ? "R3 A corner P=32" : "R1 period P=32");
      end
      apply_cfg(63, 63, 0, "R3 A=B=63 P=32");
      apply_cfg(0, 63, 0, "R3 A=0 B=63 P=32");

      // P = 64
      apply_cfg(0, 40, 1, "R3 A=0 P=64");
      apply_cfg(63, 63, 1, "R3 A=63 P=64");
      apply_cfg(21, 30, 1, "R2 period P=64");
      apply_cfg(5, 2, 1, "R7 B<A P=64");

      // B below A: every prescaler cycle stretched
      apply_cfg(40, 5, 0, "R7 B<A P=32");
      apply_cfg(3, 2, 0, "R7 B=2 A=3");
      apply_cfg(2, 2, 0, "R1 B=A=2");
      apply_cfg(17, 50, 0, "R1 period P=32");

      // Inputs without a load strobe must not matter
      @(posedge clk);
      #2;
      a_in = 6'd9;
      b_in = 11'd3;
      msel = 1'b1;
      @(negedge clk);
      check("R9 cfg_err_o unchanged without load", int'(cfg_err), 0);
      next_period(per);
      next_period(per);
      check("R9 period unchanged without load", per, cur_n);
      next_period(per);
      check("R9 period still unchanged", per, cur_n);

      check("R4 pulse width violations", width_bad, 0);

      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule